// File: doc/BRIEF.md
# Reconfigurable S-Box Lookup Memory

This block is a 2-kilobit lookup memory for cipher substitution boxes. It is built from 32 small tables. Each table has 16 entries of 4 bits, so it has 4 input bits and 4 output bits. Steering logic on the address side and the data side works on 4-bit nibbles. It lets the same physical tables act as any of these:

- 32 independent 4-to-4 boxes.
- Eight 6-to-4 boxes.
- One 8-to-8 box.
- A 16-word by 128-bit store read with a single 4-bit address. This wide mode serves as a data store or as a configuration store for neighbouring permutation logic.

Contents are loaded through a write port that addresses one table entry per cycle. Lookups are registered. The address bus and the mode select are sampled on a clock edge, and the selected data appears on the output bus after that edge.

Top module: `reconfig_sbox_mem`

## Requirements
- R1: While `rst` is high at a rising edge, `lut_data` is all zero after that edge.
- R2: Mode 0 (4-to-4). Table t is indexed by `lut_addr[4t+3:4t]`, and its entry drives `lut_data[4t+3:4t]`, for t = 0..31.
- R3: Mode 1 (6-to-4). Box b (b = 0..7) takes its 6-bit input from `lut_addr[8b+5:8b]`. Bits [8b+3:8b] index tables 4b..4b+3. Bits [8b+5:8b+4] pick table 4b plus that value. The entry appears on `lut_data[8b+3:8b]`, and `lut_data[8b+7:8b+4]` is zero.
- R4: Mode 2 (8-to-8). With x = `lut_addr[7:0]` and p = x[7:4], the output is `lut_data[3:0]` = table 2p entry x[3:0] and `lut_data[7:4]` = table 2p+1 entry x[3:0]. `lut_data[127:8]` is zero.
- R5: Mode 3 (wide). Every table is indexed by `lut_addr[3:0]`. `lut_data[4t+3:4t]` is table t's entry.
- R6: `lut_data` reflects `mode_sel` and `lut_addr` as sampled at the previous rising edge. It does not change between edges.
- R7: With `wr_en` high at an edge, table `wr_tbl` entry `wr_idx` takes `wr_data`. A lookup sampled at any later edge returns the new value.
- R8: A lookup sampled at the same edge as a write to the entry it reads returns the entry's old value.
- R9: Address bits that a mode does not use have no effect on `lut_data`. These are bits [127:8] in mode 2, and bits [8b+7:8b+6] of each lane in mode 1.
- R10: While no write occurs, a table read twice at the same entry returns the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the output path |
| mode_sel | input | 2 | 0: 4-to-4, 1: 6-to-4, 2: 8-to-8, 3: wide read |
| lut_addr | input | 128 | Lookup address bus |
| wr_en | input | 1 | Table entry write strobe |
| wr_tbl | input | 5 | Table number to write |
| wr_idx | input | 4 | Entry within the table |
| wr_data | input | 4 | Value to store |
| lut_data | output | 128 | Registered lookup result |

## Verification
The reset assertion assumes that `rst` is already high at the first clock edge. The stimulus raises it at time zero and holds it for several cycles.

The hold check assumes that the table contents change only through the write port. The stimulus loads every entry before it reads any, so no lookup returns an uninitialised entry.

Inputs change only on falling edges. The writes for the collision test are placed so that the read and the write land on the same rising edge.

// File: rtl/sbox_cfg_pkg.sv
package sbox_cfg_pkg;

    localparam int unsigned NT     = 32;
    localparam int unsigned TAW    = 4;
    localparam int unsigned TDW    = 4;
    localparam int unsigned TDEPTH = 1 << TAW;
    localparam int unsigned TSEL_W = $clog2(NT);
    localparam int unsigned ADDR_W = NT * TAW;
    localparam int unsigned BUS_W  = NT * TDW;
    localparam int unsigned NBOX6  = NT / 4;
    localparam int unsigned SEL_W  = 2 * NBOX6;

    typedef enum logic [1:0] {
        MODE_N4   = 2'd0,
        MODE_N6   = 2'd1,
        MODE_B8   = 2'd2,
        MODE_WIDE = 2'd3
    } lut_mode_e;

    typedef struct packed {
        logic              en;
        logic [TSEL_W-1:0] tbl;
        logic [TAW-1:0]    idx;
        logic [TDW-1:0]    data;
    } tbl_wr_t;

    // Bits that are always zero in 6-to-4 mode (upper nibble of each lane)
    function automatic logic [BUS_W-1:0] n6_pad_mask();
        logic [BUS_W-1:0] m;
        m = '0;
        for (int b = 0; b < int'(NBOX6); b++)
            m[b*8+4 +: 4] = 4'hF;
        return m;
    endfunction

    localparam logic [BUS_W-1:0] N6_PAD = n6_pad_mask();

endpackage

// File: rtl/sbox_addr_route.sv
module sbox_addr_route
    import sbox_cfg_pkg::*;
(
    input  lut_mode_e          mode,
    input  logic [ADDR_W-1:0]  addr_in,
    output logic [TAW-1:0]     tbl_addr [NT],
    output logic [SEL_W-1:0]   sel
);

    always_comb begin
        for (int t = 0; t < int'(NT); t++) begin
            unique case (mode)
                MODE_N4:   tbl_addr[t] = addr_in[t*TAW +: TAW];
                MODE_N6:   tbl_addr[t] = addr_in[(t/4)*8 +: TAW];
                default:   tbl_addr[t] = addr_in[0 +: TAW];
            endcase
        end
    end

    always_comb begin
        sel = '0;
        unique case (mode)
            MODE_N6: begin
                for (int b = 0; b < int'(NBOX6); b++)
                    sel[2*b +: 2] = addr_in[b*8+4 +: 2];
            end
            MODE_B8: sel[0 +: 4] = addr_in[4 +: 4];
            default: sel = '0;
        endcase
    end

endmodule

// File: rtl/sbox_table_bank.sv
module sbox_table_bank
    import sbox_cfg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  tbl_wr_t        wr,
    input  logic [TAW-1:0] tbl_addr [NT],
    output logic [TDW-1:0] rd_q     [NT]
);

    for (genvar g = 0; g < int'(NT); g++) begin : g_tbl
        logic [TDW-1:0] mem [TDEPTH];

        always_ff @(posedge clk) begin
            if (wr.en && wr.tbl == TSEL_W'(g))
                mem[wr.idx] <= wr.data;
        end

        always_ff @(posedge clk) begin
            if (rst) rd_q[g] <= '0;
            else     rd_q[g] <= mem[tbl_addr[g]];
        end

        // R10
        table_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!wr.en && $past(!wr.en) && $past(!rst) && $stable(tbl_addr[g]))
            |=> $stable(rd_q[g]));
    end

endmodule

// File: rtl/sbox_out_steer.sv
module sbox_out_steer
    import sbox_cfg_pkg::*;
(
    input  lut_mode_e          mode_q,
    input  logic [SEL_W-1:0]   sel_q,
    input  logic [TDW-1:0]     rd_q [NT],
    output logic [BUS_W-1:0]   data_out
);

    always_comb begin
        logic [TSEL_W-1:0] pick;
        data_out = '0;
        pick     = '0;
        unique case (mode_q)
            MODE_N6: begin
                for (int b = 0; b < int'(NBOX6); b++) begin
                    pick = TSEL_W'(b*4) + TSEL_W'(sel_q[2*b +: 2]);
                    data_out[b*8 +: TDW] = rd_q[pick];
                end
            end
            MODE_B8: begin
                pick = {sel_q[0 +: TSEL_W-1], 1'b0};
                data_out[0   +: TDW] = rd_q[pick];
                data_out[TDW +: TDW] = rd_q[pick | TSEL_W'(1)];
            end
            default: begin
                for (int t = 0; t < int'(NT); t++)
                    data_out[t*TDW +: TDW] = rd_q[t];
            end
        endcase
    end

endmodule

// File: rtl/reconfig_sbox_mem.sv
module reconfig_sbox_mem
    import sbox_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic [ADDR_W-1:0] lut_addr,
    input  logic              wr_en,
    input  logic [TSEL_W-1:0] wr_tbl,
    input  logic [TAW-1:0]    wr_idx,
    input  logic [TDW-1:0]    wr_data,
    output logic [BUS_W-1:0]  lut_data
);

    lut_mode_e        mode_in;
    lut_mode_e        mode_q;
    logic [SEL_W-1:0] sel_d;
    logic [SEL_W-1:0] sel_q;
    logic [TAW-1:0]   tbl_addr [NT];
    logic [TDW-1:0]   rd_q     [NT];
    tbl_wr_t          wr;

    assign mode_in = lut_mode_e'(mode_sel);
    assign wr      = '{en: wr_en, tbl: wr_tbl, idx: wr_idx, data: wr_data};

    sbox_addr_route u_route (
        .mode     (mode_in),
        .addr_in  (lut_addr),
        .tbl_addr (tbl_addr),
        .sel      (sel_d)
    );

    sbox_table_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .tbl_addr (tbl_addr),
        .rd_q     (rd_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_N4;
            sel_q  <= '0;
        end else begin
            mode_q <= mode_in;
            sel_q  <= sel_d;
        end
    end

    sbox_out_steer u_steer (
        .mode_q   (mode_q),
        .sel_q    (sel_q),
        .rd_q     (rd_q),
        .data_out (lut_data)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (lut_data == '0));

    // R4
    byte_mode_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd2) |=> (lut_data[BUS_W-1:8] == '0));

    // R3
    n6_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd1) |=> ((lut_data & N6_PAD) == '0));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && $past(!wr_en) && $past(!rst) && $stable(lut_addr) && $stable(mode_sel))
        |=> $stable(lut_data));

endmodule

// File: tb/tb_reconfig_sbox_mem.sv
module tb_reconfig_sbox_mem;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode_sel = 2'd0;
    logic [127:0] lut_addr = '0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_tbl = '0;
    logic [3:0]   wr_idx = '0;
    logic [3:0]   wr_data = '0;
    logic [127:0] lut_data;

    int checks = 0;
    int errors = 0;
    logic [3:0] ref_tbl [32][16];

    always #2 clk = ~clk;

    reconfig_sbox_mem dut (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .lut_addr(lut_addr),
        .wr_en(wr_en), .wr_tbl(wr_tbl), .wr_idx(wr_idx), .wr_data(wr_data),
        .lut_data(lut_data)
    );

    task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = '0;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] aes_sbox(input logic [7:0] v);
        logic [7:0] inv = 8'h01;
        logic [7:0] s;
        for (int i = 0; i < 254; i++) inv = gmul(inv, v);
        if (v == 8'h00) inv = 8'h00;
        s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
        return s;
    endfunction

    function automatic logic [127:0] model(input int mode, input logic [127:0] a);
        logic [127:0] r = '0;
        case (mode)
            1: for (int b = 0; b < 8; b++)
                   r[8*b +: 4] = ref_tbl[4*b + int'(a[8*b+4 +: 2])][a[8*b +: 4]];
            2: begin
                   r[3:0] = ref_tbl[2*int'(a[7:4])][a[3:0]];
                   r[7:4] = ref_tbl[2*int'(a[7:4]) + 1][a[3:0]];
               end
            default: for (int t = 0; t < 32; t++)
                   r[4*t +: 4] = ref_tbl[t][(mode == 0) ? a[4*t +: 4] : a[3:0]];
        endcase
        return r;
    endfunction

    task automatic write_entry(input int t, input int i, input logic [3:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = 5'(t); wr_idx = 4'(i); wr_data = d;
        ref_tbl[t][i] = d;
    endtask

    task automatic end_write();
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input int mode, input logic [127:0] a, input string req);
        @(negedge clk);
        mode_sel = 2'(mode); lut_addr = a;
        @(negedge clk);
        check(req, lut_data, model(mode, a));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 reset", lut_data, '0);
        rst = 1'b0;
    endtask

    task automatic t_load_random();
        for (int t = 0; t < 32; t++)
            for (int i = 0; i < 16; i++)
                write_entry(t, i, 4'($urandom));
        end_write();
    endtask

    task automatic t_n4();
        for (int v = 0; v < 16; v++) lookup(0, {32{4'(v)}}, "R2 uniform");
        for (int k = 0; k < 20; k++)
            lookup(0, {$urandom, $urandom, $urandom, $urandom}, "R2 random");
    endtask

    task automatic t_n6();
        logic [127:0] a;
        for (int v = 0; v < 64; v++) begin
            a = '0;
            for (int b = 0; b < 8; b++) a[8*b +: 6] = 6'((v + 7*b) % 64);
            lookup(1, a, "R3 six-to-four");
            for (int b = 0; b < 8; b++) a[8*b+6 +: 2] = 2'($urandom);
            lookup(1, a, "R9 six-to-four ignored bits");
        end
    endtask

    task automatic t_wide();
        for (int v = 0; v < 16; v++) lookup(3, 128'(v), "R5 wide");
    endtask

    task automatic t_latency();
        logic [127:0] a0 = {32{4'h3}};
        logic [127:0] a1 = {32{4'hC}};
        lookup(0, a0, "R6 base");
        @(negedge clk);
        lut_addr = a1;
        #1 check("R6 holds before edge", lut_data, model(0, a0));
        @(negedge clk);
        check("R6 new address", lut_data, model(0, a1));
        mode_sel = 2'd3;
        #1 check("R6 mode held before edge", lut_data, model(0, a1));
        @(negedge clk);
        check("R6 mode switch", lut_data, model(3, a1));
    endtask

    task automatic t_collide();
        logic [127:0] a = {32{4'h5}};
        logic [127:0] old_exp;
        logic [3:0] nv;
        lookup(0, a, "R2 before write");
        old_exp = model(0, a);
        nv = ~ref_tbl[3][5];
        @(negedge clk);
        wr_en = 1'b1; wr_tbl = 5'd3; wr_idx = 4'd5; wr_data = nv;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 read during write", lut_data, old_exp);
        ref_tbl[3][5] = nv;
        @(negedge clk);
        check("R7 write visible", lut_data, model(0, a));
    endtask

    task automatic t_aes();
        logic [7:0] s;
        for (int x = 0; x < 256; x++) begin
            s = aes_sbox(8'(x));
            write_entry(2*(x >> 4),     x & 15, s[3:0]);
            write_entry(2*(x >> 4) + 1, x & 15, s[7:4]);
        end
        end_write();
        for (int x = 0; x < 256; x++) begin
            @(negedge clk);
            mode_sel = 2'd2; lut_addr = 128'(x);
            @(negedge clk);
            check("R4 aes byte box", lut_data, {120'b0, aes_sbox(8'(x))});
        end
        for (int k = 0; k < 32; k++) begin
            int x = int'($urandom) & 255;
            @(negedge clk);
            lut_addr = {$urandom, $urandom, $urandom, 24'($urandom), 8'(x)};
            @(negedge clk);
            check("R9 byte box ignored bits", lut_data, {120'b0, aes_sbox(8'(x))});
        end
        check("R4 known value 0x53", 128'(aes_sbox(8'h53)), 128'hED);
    endtask

    task automatic t_hold();
        logic [127:0] first;
        lookup(3, 128'h9, "R10 first read");
        first = lut_data;
        repeat (5) @(negedge clk);
        check("R10 repeat read", lut_data, first);
    endtask

    initial begin
        t_reset();
        t_load_random();
        t_n4();
        t_n6();
        t_wide();
        t_latency();
        t_collide();
        t_hold();
        t_aes();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule